// File: doc/BRIEF.md
# Dual-Mode Shutter Readout Sequencer

This block is the timing controller for a pixel array built from two pixel types that share one row-select line and one reset line, and whose overflow gates and transfer gates each follow a single common waveform. For every selected row it produces three ADC sample strobes, each tagged with a sample index and the row address. The three samples are packed as closely as the required gate pulses allow. The analog drive levels for each pixel type are set outside this block, so the block produces only one timing waveform per signal pair.

Two schedules are supported, and the mode bit is captured when a frame starts. In rolling mode each row time selects a row with its reset held, then releases reset and samples the reset level. It then pulses the transfer gates, which ends that row's exposure, and samples the signal level. Next it raises the overflow and transfer gates together, drops the overflow gates, drops the transfer gates one cycle later, and samples the integration-capacitor reset level. An exposure pointer leads the readout by a programmed number of row times, so each row is exposed for exactly that many row times. In global mode a frame overhead period resets the whole array, with the overflow and transfer gates both on. Lowering the overflow gates starts the exposure, and turning the transfer gates off ends it for every row at once. Each row is then read in a different order: signal level, a reset pulse, the reset level, a transfer pulse, and a third sample.

Each phase length comes from an input field, and a value of zero is taken as one cycle. A busy flag covers the whole frame.

Top module: `shutter_seq`

## Requirements
- R1: After reset and whenever no frame is running, every output is 0: busy_o, sel_o, rst_o, tx_o, ovg_o, smp_o, exp_start_o, smp_idx_o, row_o and exp_row_o.
- R2: A high start_i while idle starts a frame and captures global_mode_i (1 = global, 0 = rolling). Changes to global_mode_i during a frame have no effect on that frame, and start_i pulses during a frame are ignored.
- R3: Rolling row time, with S = settle length and T = transfer length: sel_o and rst_o are both high for S cycles. This is followed by a sample with index 0, then tx_o high for T cycles, then a sample with index 1. sel_o stays high for the whole row time.
- R4: Rolling third phase, with P = pulse length: ovg_o and tx_o are both high for P cycles, then tx_o alone is high for 1 cycle, then comes a sample with index 2. One row time lasts S+T+P+4 cycles.
- R5: Global frame start, with F = overhead length and X = exposure length in cycles: ovg_o and tx_o are both high for F cycles with sel_o low. Then tx_o alone is high for X cycles, and then row readout begins.
- R6: Global row time: sel_o is high for S cycles before a sample with index 0. Then rst_o is high for P cycles (with tx_o low), followed by a sample with index 1. Then tx_o is high for T cycles, followed by a sample with index 2. One row time lasts S+P+T+3 cycles.
- R7: Each read row gives exactly three one-cycle strobes on smp_o, with smp_idx_o equal to 0, 1 and 2 in that order. row_o carries the row address, counting from 0, while sel_o is high, and is 0 otherwise. smp_o is never high while sel_o is low.
- R8: A phase length input of 0 behaves exactly like a length of 1.
- R9: In rolling mode a frame has N+E row times, where N is the number of rows and E is the exposure length in row times. Row time k raises exp_start_o for one cycle with exp_row_o = k if k < N, in the cycle that holds sample index 0. The row read in row time k is k-E, and nothing is selected when k < E.
- R10: busy_o rises in the cycle after the start edge and stays high until the third sample of the last row. It falls in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Frame start request |
| global_mode_i | input | 1 | 1 = global schedule, 0 = rolling schedule |
| num_rows_i | input | ROW_W | Number of rows per frame (at least 1) |
| exp_len_i | input | EXP_W | Exposure: row times (rolling) or cycles (global) |
| settle_len_i | input | DUR_W | Row settle length in cycles |
| tx_len_i | input | DUR_W | Transfer pulse length in cycles |
| pulse_len_i | input | DUR_W | Reset / overflow pulse length in cycles |
| foh_len_i | input | DUR_W | Global frame overhead length in cycles |
| busy_o | output | 1 | Frame in progress |
| sel_o | output | 1 | Row select |
| rst_o | output | 1 | Reset line |
| tx_o | output | 1 | Transfer-gate timing |
| ovg_o | output | 1 | Overflow-gate timing |
| smp_o | output | 1 | One-cycle ADC sample strobe |
| smp_idx_o | output | 2 | Sample index 0..2 |
| row_o | output | ROW_W | Address of the selected row |
| exp_start_o | output | 1 | Rolling exposure-start strobe |
| exp_row_o | output | ROW_W | Row whose exposure starts |

## Verification
The assertions assume that num_rows_i is at least 1. They also assume that the row count, exposure and phase-length inputs stay constant for the whole frame, because row addresses and the frame end are computed from them directly. The stimulus changes these fields only while the block is idle, before each start pulse. Only global_mode_i and start_i are disturbed during a frame, and only to confirm that the block ignores them. The expected waveform of every output is computed cycle by cycle from the offset arithmetic in the requirements. This is done over sweeps of both modes, one to three rows, several exposure values and several phase lengths.

// File: rtl/shutter_seq_pkg.sv
package shutter_seq_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_FOT,
    ST_EXPO,
    ST_SEL,
    ST_S1,
    ST_TXP,
    ST_S2,
    ST_OVP,
    ST_TXT,
    ST_RSTP,
    ST_S3
  } seq_st_e;
endpackage

// File: rtl/shutter_seq_phase_cnt.sv
module shutter_seq_phase_cnt #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d, len_m1;

  // zero length is treated as a single cycle
  assign len_m1 = (len_i == '0) ? '0 : len_i - 1'b1;

  always_comb begin
    cnt_d = cnt_q;
    if (load_i)
      cnt_d = len_m1;
    else if (cnt_q != '0)
      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign done_o = (cnt_q == '0);
endmodule

// File: rtl/shutter_seq_slot_cnt.sv
module shutter_seq_slot_cnt #(
  parameter int SLOT_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              adv_i,
  input  logic [SLOT_W-1:0] last_val_i,
  output logic [SLOT_W-1:0] slot_o,
  output logic              last_o
);
  logic [SLOT_W-1:0] slot_q, slot_d;
  logic              slot_en;

  assign slot_en = clr_i | adv_i;

  always_comb begin
    slot_d = slot_q;
    if (clr_i)      slot_d = '0;
    else if (adv_i) slot_d = slot_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       slot_q <= '0;
    else if (slot_en) slot_q <= slot_d;
  end

  assign slot_o = slot_q;
  assign last_o = (slot_q == last_val_i);
endmodule

// File: rtl/shutter_seq.sv
module shutter_seq
  import shutter_seq_pkg::*;
#(
  parameter int ROW_W = 9,
  parameter int DUR_W = 8,
  parameter int EXP_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             global_mode_i,
  input  logic [ROW_W-1:0] num_rows_i,
  input  logic [EXP_W-1:0] exp_len_i,
  input  logic [DUR_W-1:0] settle_len_i,
  input  logic [DUR_W-1:0] tx_len_i,
  input  logic [DUR_W-1:0] pulse_len_i,
  input  logic [DUR_W-1:0] foh_len_i,
  output logic             busy_o,
  output logic             sel_o,
  output logic             rst_o,
  output logic             tx_o,
  output logic             ovg_o,
  output logic             smp_o,
  output logic [1:0]       smp_idx_o,
  output logic [ROW_W-1:0] row_o,
  output logic             exp_start_o,
  output logic [ROW_W-1:0] exp_row_o
);
  localparam int CNT_W  = (DUR_W > EXP_W) ? DUR_W : EXP_W;
  localparam int SLOT_W = ((ROW_W > EXP_W) ? ROW_W : EXP_W) + 1;

  seq_st_e           st_q, st_d;
  logic              glob_q, glob_d, mode_en;
  logic              ph_done, ph_load;
  logic [CNT_W-1:0]  ph_len;
  logic [SLOT_W-1:0] slot, last_val, rows_w, exp_w, row_calc;
  logic              slot_last, slot_clr, slot_adv;
  logic              idle, row_st, rd_ok, row_act;

  assign idle    = (st_q == ST_IDLE);
  assign mode_en = idle & start_i;
  assign glob_d  = global_mode_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       glob_q <= 1'b0;
    else if (mode_en) glob_q <= glob_d;
  end

  // next-state logic
  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (start_i) st_d = global_mode_i ? ST_FOT : ST_SEL;
      ST_FOT:  if (ph_done) st_d = ST_EXPO;
      ST_EXPO: if (ph_done) st_d = ST_SEL;
      ST_SEL:  if (ph_done) st_d = ST_S1;
      ST_S1:   st_d = glob_q ? ST_RSTP : ST_TXP;
      ST_TXP:  if (ph_done) st_d = glob_q ? ST_S3 : ST_S2;
      ST_S2:   st_d = glob_q ? ST_TXP : ST_OVP;
      ST_OVP:  if (ph_done) st_d = ST_TXT;
      ST_TXT:  st_d = ST_S3;
      ST_RSTP: if (ph_done) st_d = ST_S2;
      ST_S3:   st_d = slot_last ? ST_IDLE : ST_SEL;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  // phase length of the state being entered
  always_comb begin
    unique case (st_d)
      ST_FOT:         ph_len = CNT_W'(foh_len_i);
      ST_EXPO:        ph_len = CNT_W'(exp_len_i);
      ST_SEL:         ph_len = CNT_W'(settle_len_i);
      ST_TXP:         ph_len = CNT_W'(tx_len_i);
      ST_OVP, ST_RSTP: ph_len = CNT_W'(pulse_len_i);
      default:        ph_len = CNT_W'(1);
    endcase
  end
  assign ph_load = (st_d != st_q);

  shutter_seq_phase_cnt #(.CNT_W(CNT_W)) phase_i (
    .clk(clk), .rst_n(rst_n), .load_i(ph_load), .len_i(ph_len), .done_o(ph_done)
  );

  // row-time counter: rolling frames add E leading row times
  assign rows_w   = SLOT_W'(num_rows_i);
  assign exp_w    = SLOT_W'(exp_len_i);
  assign last_val = glob_q ? rows_w - 1'b1 : rows_w + exp_w - 1'b1;
  assign slot_clr = mode_en;
  assign slot_adv = (st_q == ST_S3) & ~slot_last;

  shutter_seq_slot_cnt #(.SLOT_W(SLOT_W)) slot_i (
    .clk(clk), .rst_n(rst_n), .clr_i(slot_clr), .adv_i(slot_adv),
    .last_val_i(last_val), .slot_o(slot), .last_o(slot_last)
  );

  // output decode
  assign row_st   = ~idle & (st_q != ST_FOT) & (st_q != ST_EXPO);
  assign rd_ok    = glob_q | (slot >= exp_w);
  assign row_act  = row_st & rd_ok;
  assign row_calc = glob_q ? slot : slot - exp_w;

  assign busy_o    = ~idle;
  assign sel_o     = row_act;
  assign rst_o     = row_act & (glob_q ? (st_q == ST_RSTP) : (st_q == ST_SEL));
  assign tx_o      = (row_act & ((st_q == ST_TXP) | (st_q == ST_OVP) | (st_q == ST_TXT)))
                   | (glob_q & ((st_q == ST_FOT) | (st_q == ST_EXPO)));
  assign ovg_o     = (row_act & (st_q == ST_OVP)) | (glob_q & (st_q == ST_FOT));
  assign smp_o     = row_act & ((st_q == ST_S1) | (st_q == ST_S2) | (st_q == ST_S3));
  assign smp_idx_o = !smp_o ? 2'd0 : (st_q == ST_S1) ? 2'd0 : (st_q == ST_S2) ? 2'd1 : 2'd2;
  assign row_o     = row_act ? ROW_W'(row_calc) : '0;
  assign exp_start_o = ~glob_q & (st_q == ST_S1) & (slot < rows_w);
  assign exp_row_o   = exp_start_o ? ROW_W'(slot) : '0;

  // R7
  smp_sel_chk: assert property (@(posedge clk) disable iff (!rst_n) smp_o |-> sel_o);
  // R7
  smp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) smp_o |=> !smp_o);
  // R4
  ovg_tx_chk: assert property (@(posedge clk) disable iff (!rst_n) $fell(ovg_o) |-> tx_o);
  // R6
  rst_tx_chk: assert property (@(posedge clk) disable iff (!rst_n) rst_o |-> !tx_o);
  // R10
  busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> $past(smp_o && (smp_idx_o == 2'd2)));
  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !(sel_o || tx_o || ovg_o || smp_o || exp_start_o));
endmodule

// File: tb/shutter_seq_tb_top.sv
module shutter_seq_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0;
  logic       global_mode_i = 1'b0;
  logic [8:0] num_rows_i = 9'd1;
  logic [9:0] exp_len_i = 10'd0;
  logic [7:0] settle_len_i = 8'd1, tx_len_i = 8'd1, pulse_len_i = 8'd1, foh_len_i = 8'd1;
  logic       busy_o, sel_o, rst_o, tx_o, ovg_o, smp_o, exp_start_o;
  logic [1:0] smp_idx_o;
  logic [8:0] row_o, exp_row_o;

  int checks = 0;
  int fails = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  shutter_seq dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .global_mode_i(global_mode_i),
    .num_rows_i(num_rows_i), .exp_len_i(exp_len_i), .settle_len_i(settle_len_i),
    .tx_len_i(tx_len_i), .pulse_len_i(pulse_len_i), .foh_len_i(foh_len_i),
    .busy_o(busy_o), .sel_o(sel_o), .rst_o(rst_o), .tx_o(tx_o), .ovg_o(ovg_o),
    .smp_o(smp_o), .smp_idx_o(smp_idx_o), .row_o(row_o),
    .exp_start_o(exp_start_o), .exp_row_o(exp_row_o)
  );

  function automatic logic [26:0] act_vec();
    return {busy_o, sel_o, rst_o, tx_o, ovg_o, smp_o, smp_idx_o, row_o, exp_start_o, exp_row_o};
  endfunction

  function automatic int mx1(int v);
    return (v < 1) ? 1 : v;
  endfunction

  // expected outputs in cycle c after the start edge
  function automatic logic [26:0] exp_vec(bit g, int n, int e, int s0, int t0, int p0, int f0, int c);
    logic bz = 0, sl = 0, rs = 0, tx = 0, ov = 0, sm = 0, xs = 0;
    logic [1:0] ix = 0;
    logic [8:0] rw = 0, xr = 0;
    int s = mx1(s0), t = mx1(t0), p = mx1(p0), f = mx1(f0), x = mx1(e);
    int len, slot, off, base;
    if (!g) begin
      len = s + t + p + 4;
      if (c < (n + e) * len) begin
        bz = 1; slot = c / len; off = c % len;
        if (slot < n && off == s) begin xs = 1; xr = 9'(slot); end
        if (slot >= e) begin
          sl = 1; rw = 9'(slot - e);
          if (off < s) rs = 1;
          else if (off == s) begin sm = 1; ix = 0; end
          else if (off < s + 1 + t) tx = 1;
          else if (off == s + 1 + t) begin sm = 1; ix = 1; end
          else if (off < s + t + 2 + p) begin ov = 1; tx = 1; end
          else if (off == s + t + p + 2) tx = 1;
          else begin sm = 1; ix = 2; end
        end
      end
    end else begin
      len = s + p + t + 3; base = f + x;
      if (c < f) begin bz = 1; ov = 1; tx = 1; end
      else if (c < base) begin bz = 1; tx = 1; end
      else if (c - base < n * len) begin
        bz = 1; sl = 1; slot = (c - base) / len; off = (c - base) % len; rw = 9'(slot);
        if (off == s) begin sm = 1; ix = 0; end
        else if (off > s && off < s + 1 + p) rs = 1;
        else if (off == s + 1 + p) begin sm = 1; ix = 1; end
        else if (off > s + 1 + p && off < s + p + t + 2) tx = 1;
        else if (off == s + p + t + 2) begin sm = 1; ix = 2; end
      end
    end
    return {bz, sl, rs, tx, ov, sm, ix, rw, xs, xr};
  endfunction

  task automatic run_frame(bit g, int n, int e, int s, int t, int p, int f, bit disturb, string tag);
    int total, len, bad_c;
    logic [26:0] ev, av, bad_a, bad_e;
    bit bad;
    @(negedge clk);
    global_mode_i = g; num_rows_i = 9'(n); exp_len_i = 10'(e);
    settle_len_i = 8'(s); tx_len_i = 8'(t); pulse_len_i = 8'(p); foh_len_i = 8'(f);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    if (!g) begin
      len = mx1(s) + mx1(t) + mx1(p) + 4; total = (n + e) * len;
    end else begin
      len = mx1(s) + mx1(p) + mx1(t) + 3; total = mx1(f) + mx1(e) + n * len;
    end
    bad = 0; bad_c = 0; bad_a = 0; bad_e = 0;
    for (int c = 0; c < total + 2; c++) begin
      if (c > 0) @(negedge clk);
      start_i = 1'b0;
      ev = exp_vec(g, n, e, s, t, p, f, c);
      av = act_vec();
      if (av !== ev && !bad) begin bad = 1; bad_c = c; bad_a = av; bad_e = ev; end
      if (disturb && c == 3) begin global_mode_i = ~g; start_i = 1'b1; end
    end
    checks++;
    if (bad) begin
      fails++;
      $display("FAIL %s mode=%0d n=%0d e=%0d cycle %0d: actual %h expected %h",
               tag, g, n, e, bad_c, bad_a, bad_e);
    end
  endtask

  initial begin
    while (cyc < 150000) begin @(posedge clk); cyc++; end
    fails++; checks++;
    $display("FAIL R10 watchdog: actual hung expected frame end");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    checks++;
    if (act_vec() !== 27'd0) begin
      fails++; $display("FAIL R1 in reset: actual %h expected 0", act_vec());
    end
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    checks++;
    if (act_vec() !== 27'd0) begin
      fails++; $display("FAIL R1 idle after reset: actual %h expected 0", act_vec());
    end
    // sweeps: R3 R4 R7 R9 R10 (rolling), R5 R6 R7 R10 (global), R1 idle tail
    for (int g = 0; g < 2; g++)
      for (int n = 1; n <= 3; n++)
        for (int e = 0; e <= 2; e++)
          for (int s = 1; s <= 2; s++)
            for (int t = 1; t <= 3; t += 2)
              for (int p = 1; p <= 2; p++)
                for (int f = 1; f <= 2; f++)
                  run_frame(g[0], n, e, s, t, p, f, 1'b0,
                            g ? "R5/R6/R7/R10/R1" : "R3/R4/R7/R9/R10/R1");
    // R8: zero phase lengths behave as one cycle
    run_frame(1'b0, 2, 1, 0, 0, 0, 0, 1'b0, "R8 rolling");
    run_frame(1'b1, 2, 0, 0, 0, 0, 0, 1'b0, "R8 global");
    // R2: mode change and start pulse during a frame are ignored
    run_frame(1'b0, 3, 1, 2, 1, 1, 1, 1'b1, "R2 rolling");
    run_frame(1'b1, 3, 2, 1, 2, 1, 2, 1'b1, "R2 global");
    // larger rolling lead
    run_frame(1'b0, 4, 5, 3, 2, 3, 1, 1'b0, "R9 long lead");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule